// File: doc/BRIEF.md
# Delayed-Pair Inner Product Checker

This block is a passive station on the vector stream of a chain of repeated sparse matrix-by-vector products over GF(2). It checks the chain for faults. While each product vector streams past, a few lanes per beat, the block reduces it to two parity words per chain. One parity is taken against a fixed test vector b, the other against a fixed vector c. The b and c bits for each beat arrive as lane masks beside the data. Several independent chains travel together: every vector element is a tuple with one bit per chain, and each chain has its own accumulators and its own history.

The c parity of every finished product is pushed into a queue that is `DEPTH` entries deep. The b parity of the product that just finished is compared with the oldest entry in that queue, which is the c parity from `DEPTH` products earlier. A difference in any chain means that at least one of the recent products is faulty. The block then raises a sticky fault flag, records which chains disagreed, and keeps the index of the first product that failed. Before a chain starts, the queue is filled with `DEPTH` values computed outside the block; these stand in for the missing history. Checking carries on for as many products as are streamed, so the host can run `DEPTH` extra products after the last real one and have the final products covered too.

The stream input uses a valid/ready handshake. A beat is taken on a cycle where `s_valid` and `s_ready` are both high. `s_ready` drops only while `start` or `preload_valid` is high. While `s_ready` is low, the source must hold the beat and offer it again later. Idle cycles between beats are allowed anywhere.

Top module: `dp_checker`

## Requirements
- R1: Per chain c and per accepted beat, the b term is the XOR over lanes l where `s_bmask[l]`=1 of data bit `s_data[l*CHAINS+c]`, and the c term is formed the same way with `s_cmask`. The terms are XOR-accumulated over every beat up to and including the beat with `s_last`=1.
- R2: When the last beat of a product is accepted, each chain's b result is compared with the oldest history entry. Any difference sets `fault` and the matching `fault_chains` bits. These outputs are visible in the cycle after that beat.
- R3: `fault` and `fault_chains` are sticky. Bits are only ever added until `clear` is pulsed. After reset they are zero.
- R4: `fault_idx` holds the product index of the first mismatch, counted from 0 at the last `start`. Later mismatches do not change it.
- R5: Each cycle with `preload_valid` high pushes `preload_data` into the history. Of `DEPTH` pushes made after `start`, the first is compared against product 0, the second against product 1, and so on.
- R6: `start` zeroes both accumulators, the product index and the history. A partly streamed vector is thrown away.
- R7: `s_ready` is low while `start` or `preload_valid` is high. A beat offered in such a cycle is not taken and has no effect on the parities.
- R8: Once the preloaded entries are used up, each product i is compared against the c result that product i-`DEPTH` pushed. This continues for any number of products.
- R9: `clear` zeroes `fault`, `fault_chains` and `fault_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new chain: clear accumulators, index and history |
| clear | input | 1 | Clear the fault outputs |
| preload_valid | input | 1 | Push `preload_data` into the history |
| preload_data | input | CHAINS | Externally computed c parity, one bit per chain |
| s_valid | input | 1 | Stream beat is offered |
| s_ready | output | 1 | Stream beat can be taken |
| s_data | input | LANES*CHAINS | Vector tuples; lane l, chain c at bit l*CHAINS+c |
| s_bmask | input | LANES | b test bits for this beat's lanes |
| s_cmask | input | LANES | c test bits for this beat's lanes |
| s_last | input | 1 | Beat ends the current product vector |
| fault | output | 1 | Sticky mismatch flag |
| fault_chains | output | CHAINS | Sticky per-chain mismatch bits |
| fault_idx | output | IDX_W | Index of the first mismatching product |

## Verification
The hardest state to reach from the ports is a long chain that is fully consistent, where every b parity equals the c parity from `DEPTH` products earlier. With random data, nearly every product would mismatch. To build such a chain, the bench sets one lane of the final beat to b=1, c=0 and computes that lane's data so the b parity hits a chosen target, without touching the c parity. The target is a preloaded value for the first `DEPTH` products and the recorded c parity after that. Single chain bits are then flipped at chosen products to inject faults. The sweep covers every chain, early and late fault positions, a second fault after the first, idle gaps between beats, and beats offered while a preload is in progress.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int DPC_DEPTH  = 8;
  localparam int DPC_LANES  = 4;
  localparam int DPC_CHAINS = 4;
  localparam int DPC_IDX_W  = 16;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_START = 2'd1,
    OP_LOAD  = 2'd2,
    OP_BEAT  = 2'd3
  } dpc_op_e;
endpackage

// File: rtl/dpc_fold.sv
module dpc_fold #(
  parameter int LANES  = 4,
  parameter int CHAINS = 4
) (
  input  logic [LANES*CHAINS-1:0] data,
  input  logic [LANES-1:0]        mask,
  output logic [CHAINS-1:0]       par
);
  always_comb begin
    par = '0;
    for (int l = 0; l < LANES; l++) begin
      if (mask[l]) par = par ^ data[l*CHAINS +: CHAINS];
    end
  end
endmodule

// File: rtl/dpc_acc.sv
module dpc_acc #(
  parameter int LANES  = 4,
  parameter int CHAINS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic                    last,
  input  logic [LANES*CHAINS-1:0] data,
  input  logic [LANES-1:0]        mask,
  output logic [CHAINS-1:0]       res
);
  logic [CHAINS-1:0] acc_q;
  logic [CHAINS-1:0] beat_par;

  dpc_fold #(.LANES(LANES), .CHAINS(CHAINS)) fold_i (
    .data(data), .mask(mask), .par(beat_par)
  );

  assign res = acc_q ^ beat_par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             acc_q <= '0;
    else if (clr)           acc_q <= '0;
    else if (en && last)    acc_q <= '0;
    else if (en)            acc_q <= res;
  end

  // R6
  acc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> acc_q == '0);
endmodule

// File: rtl/dpc_history.sv
module dpc_history #(
  parameter int DEPTH  = 8,
  parameter int CHAINS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [CHAINS-1:0] din,
  output logic [CHAINS-1:0] oldest
);
  logic [CHAINS-1:0] stage_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stage_q[0] <= '0;
    else if (clr)   stage_q[0] <= '0;
    else if (push)  stage_q[0] <= din;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stage_q[s] <= '0;
      else if (clr)   stage_q[s] <= '0;
      else if (push)  stage_q[s] <= stage_q[s-1];
    end
  end

  assign oldest = stage_q[DEPTH-1];

  // R5
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !clr) |=> $stable(oldest));
endmodule

// File: rtl/dp_checker.sv
module dp_checker
  import dpc_pkg::*;
#(
  parameter int DEPTH  = DPC_DEPTH,
  parameter int LANES  = DPC_LANES,
  parameter int CHAINS = DPC_CHAINS,
  parameter int IDX_W  = DPC_IDX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    clear,
  input  logic                    preload_valid,
  input  logic [CHAINS-1:0]       preload_data,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [LANES*CHAINS-1:0] s_data,
  input  logic [LANES-1:0]        s_bmask,
  input  logic [LANES-1:0]        s_cmask,
  input  logic                    s_last,
  output logic                    fault,
  output logic [CHAINS-1:0]       fault_chains,
  output logic [IDX_W-1:0]        fault_idx
);
  dpc_op_e           op;
  logic              beat, done, push;
  logic [CHAINS-1:0] b_res, c_res, hist_old, hist_din, mism;
  logic [IDX_W-1:0]  prod_idx;

  always_comb begin
    if (start)              op = OP_START;
    else if (preload_valid) op = OP_LOAD;
    else if (s_valid)       op = OP_BEAT;
    else                    op = OP_IDLE;
  end

  assign s_ready  = !start && !preload_valid;
  assign beat     = (op == OP_BEAT);
  assign done     = beat && s_last;
  assign push     = (op == OP_LOAD) || done;
  assign hist_din = (op == OP_LOAD) ? preload_data : c_res;
  assign mism     = done ? (b_res ^ hist_old) : '0;

  dpc_acc #(.LANES(LANES), .CHAINS(CHAINS)) b_acc_i (
    .clk(clk), .rst_n(rst_n), .clr(start), .en(beat), .last(s_last),
    .data(s_data), .mask(s_bmask), .res(b_res)
  );

  dpc_acc #(.LANES(LANES), .CHAINS(CHAINS)) c_acc_i (
    .clk(clk), .rst_n(rst_n), .clr(start), .en(beat), .last(s_last),
    .data(s_data), .mask(s_cmask), .res(c_res)
  );

  dpc_history #(.DEPTH(DEPTH), .CHAINS(CHAINS)) hist_i (
    .clk(clk), .rst_n(rst_n), .clr(start), .push(push),
    .din(hist_din), .oldest(hist_old)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prod_idx <= '0;
    else if (start)  prod_idx <= '0;
    else if (done)   prod_idx <= prod_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault        <= 1'b0;
      fault_chains <= '0;
      fault_idx    <= '0;
    end else begin
      if (clear) begin
        fault        <= 1'b0;
        fault_chains <= '0;
        fault_idx    <= '0;
      end
      if (mism != '0) begin
        fault        <= 1'b1;
        fault_chains <= (clear ? '0 : fault_chains) | mism;
        if (!fault || clear) fault_idx <= prod_idx;
      end
    end
  end

  // R3
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !clear) |=> fault);
  // R3
  chains_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (($past(fault_chains) & ~fault_chains) == '0));
  // R4
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !clear) |=> $stable(fault_idx));
  // R7
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start || preload_valid) |-> !s_ready);
  // R2
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(s_valid && s_ready && s_last));
  // R6
  idx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> prod_idx == '0);
endmodule

// File: tb/dp_checker_tb.sv
module dp_checker_tb_top;
  localparam int D = 8;
  localparam int L = 4;
  localparam int C = 4;
  localparam int W = 16;
  localparam int VB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, clear = 1'b0, preload_valid = 1'b0;
  logic [C-1:0] preload_data = '0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic s_ready;
  logic [L*C-1:0] s_data = '0;
  logic [L-1:0] s_bmask = '0, s_cmask = '0;
  logic fault;
  logic [C-1:0] fault_chains;
  logic [W-1:0] fault_idx;

  always #5 clk = ~clk;

  dp_checker #(.DEPTH(D), .LANES(L), .CHAINS(C), .IDX_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .clear(clear),
    .preload_valid(preload_valid), .preload_data(preload_data),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_bmask(s_bmask), .s_cmask(s_cmask), .s_last(s_last),
    .fault(fault), .fault_chains(fault_chains), .fault_idx(fault_idx)
  );

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  logic [L-1:0] bm [VB];
  logic [L-1:0] cm [VB];
  logic [C-1:0] cw  [32];
  logic [C-1:0] pre [D];
  bit expf;
  logic [C-1:0] expch;
  int expidx;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_fault(input string req);
    check(fault == expf, req, int'(fault), int'(expf));
    check(fault_chains == expch, req, int'(fault_chains), int'(expch));
    check(int'(fault_idx) == expidx, req, int'(fault_idx), expidx);
  endtask

  task automatic push_beat(input logic [L*C-1:0] d, input logic [L-1:0] b,
                           input logic [L-1:0] c, input bit last, input bit gap);
    s_valid = 1'b1; s_data = d; s_bmask = b; s_cmask = c; s_last = last;
    @(posedge clk); @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    if (gap) @(negedge clk);
  endtask

  // R1: data shaped so the b parity equals tgt; c parity is recorded
  task automatic do_product(input int i, input logic [C-1:0] tgt, input bit gap);
    logic [C-1:0] pb, pc;
    logic [L*C-1:0] d;
    pb = '0; pc = '0;
    for (int j = 0; j < VB; j++) begin
      d = L*C'($urandom);
      if (j == VB-1) d[C-1:0] = '0;
      for (int l = 0; l < L; l++) begin
        if (bm[j][l]) pb ^= d[l*C +: C];
        if (cm[j][l]) pc ^= d[l*C +: C];
      end
      if (j == VB-1) d[C-1:0] = pb ^ tgt;
      push_beat(d, bm[j], cm[j], j == VB-1, gap);
    end
    cw[i] = pc;
  endtask

  task automatic run_chain(input int n, input int fp1, input logic [C-1:0] fm1,
                           input int fp2, input logic [C-1:0] fm2,
                           input bit gap, input bit noise);
    logic [C-1:0] tgt, mm;
    clear = 1'b1; start = 1'b1;
    @(posedge clk); @(negedge clk);
    clear = 1'b0; start = 1'b0;
    expf = 1'b0; expch = '0; expidx = 0;
    check_fault("R9 R6 chain start");
    for (int i = 0; i < D; i++) begin
      pre[i] = C'($urandom);
      preload_valid = 1'b1; preload_data = pre[i];
      if (noise) begin
        s_valid = 1'b1; s_last = 1'b1; s_data = L*C'($urandom);
        s_bmask = '1; s_cmask = '1;
      end
      #1;
      check(s_ready == 1'b0, "R7 ready low in preload", int'(s_ready), 0);
      @(posedge clk); @(negedge clk);
      preload_valid = 1'b0; s_valid = 1'b0; s_last = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      mm = '0;
      if (i == fp1) mm = fm1;
      if (i == fp2) mm = mm | fm2;
      tgt = ((i < D) ? pre[i] : cw[i-D]) ^ mm;
      do_product(i, tgt, gap);
      if (mm != '0) begin
        if (!expf) expidx = i;
        expf = 1'b1;
        expch = expch | mm;
      end
      if (i < D) check_fault("R1 R2 R5 R7 product vs preload");
      else       check_fault("R1 R2 R3 R4 R8 product vs history");
    end
  endtask

  initial begin
    bm[0] = 4'b0110; cm[0] = 4'b1011;
    bm[1] = 4'b1011; cm[1] = 4'b1110;
    bm[2] = 4'b1101; cm[2] = 4'b0110;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(fault == 1'b0, "R3 reset fault", int'(fault), 0);
    check(fault_chains == '0, "R3 reset chains", int'(fault_chains), 0);
    check(fault_idx == '0, "R4 reset idx", int'(fault_idx), 0);
    check(s_ready == 1'b1, "R7 reset ready", int'(s_ready), 1);

    run_chain(20, -1, '0, -1, '0, 1'b0, 1'b0);
    for (int ch = 0; ch < C; ch++) begin
      for (int p = 0; p < 4; p++) begin
        int fp;
        fp = (p == 0) ? 0 : (p == 1) ? 5 : (p == 2) ? 8 : 13;
        run_chain(20, fp, C'(1 << ch), fp + 3, C'(1 << ((ch + 1) % C)),
                  bit'(ch % 2), bit'(p == 2));
      end
    end

    // R9: clear alone after a faulting chain
    clear = 1'b1; @(posedge clk); @(negedge clk); clear = 1'b0;
    check(fault == 1'b0, "R9 clear fault", int'(fault), 0);
    check(fault_chains == '0, "R9 clear chains", int'(fault_chains), 0);
    check(fault_idx == '0, "R9 clear idx", int'(fault_idx), 0);

    // R6: a partial vector then start; the remainder must stay clean
    push_beat(L*C'($urandom), 4'b1111, 4'b1111, 1'b0, 1'b0);
    push_beat(L*C'($urandom), 4'b1111, 4'b1111, 1'b0, 1'b0);
    run_chain(20, -1, '0, -1, '0, 1'b1, 1'b0);
    check(fault == 1'b0, "R6 partial vector discarded", int'(fault), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule